// File: doc/BRIEF.md
# Rotate and Bit-Manipulation Unit

A 16-bit datapath unit that runs one of ten operations per start pulse: plain rotates left and right, rotates left and right through the carry flag, four single-bit test forms and two bit scans. Each request presents an operation code, a data operand, a count or bit index, a destination value for the scans, and the incoming carry and zero flags. The unit computes the new value and the new carry and zero flags in one combinational pass. It registers them on the clock edge that samples the start pulse.

The request side has no back-pressure. Every cycle in which `start` is high is accepted, so a new operation may be issued on every cycle. `done` is a one-cycle strobe that follows each accepted request by exactly one cycle. The consumer must take `result`, `cf_out` and `zf_out` while `done` is high, or any later cycle up to the next strobe, because the outputs hold their value between requests.

Top module: `bitrot_unit`

## Requirements
- R1: For op 0 (rotate left) and op 1 (rotate right) with a nonzero 5-bit count, the operand is rotated by count mod 16. `cf_out` is the last bit carried across the end: result bit 0 for a left rotate, result bit 15 for a right rotate. `zf_out` equals `zf_in`.
- R2: For op 2 (left through carry) and op 3 (right through carry), the 17-bit value {cf_in, operand} is rotated by count mod 17. `cf_out` is its top bit and `result` is its low 16 bits. Rotating 0x4020 left with carry 1 by 5 gives 0x0414 with carry 0. `zf_out` equals `zf_in`.
- R3: For ops 0 to 3, a count of zero returns the operand unchanged, with `cf_out` = `cf_in` and `zf_out` = `zf_in`.
- R4: For op 4 (test), `cf_out` is operand bit (count mod 16), `result` equals the operand and `zf_out` equals `zf_in`.
- R5: For op 5 (test-and-set), op 6 (test-and-clear) and op 7 (test-and-invert), `cf_out` is the original operand bit (count mod 16). `result` is the operand with that one bit set, cleared or inverted. `zf_out` equals `zf_in`.
- R6: For op 8 (forward scan) with a nonzero operand, `result` is the index of the lowest set bit, `zf_out` is 0 and `cf_out` equals `cf_in`.
- R7: For op 9 (reverse scan) with a nonzero operand, `result` is the index of the highest set bit, `zf_out` is 0 and `cf_out` equals `cf_in`.
- R8: For ops 8 and 9 with a zero operand, `zf_out` is 1, `result` equals `dest_in` and `cf_out` equals `cf_in`.
- R9: Each cycle with `start` high raises `done` for exactly the following cycle, with that request's outputs. Requests may arrive on consecutive cycles.
- R10: After reset, `result`, `cf_out`, `zf_out` and `done` are 0. The outputs hold their value in every cycle after a cycle without `start`.
- R11: Op codes 10 to 15 return the operand unchanged, with `cf_out` = `cf_in` and `zf_out` = `zf_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a request this cycle |
| op | input | 4 | Operation code (0 to 9 defined) |
| operand | input | 16 | Data operand |
| dest_in | input | 16 | Destination value kept by a scan of zero |
| count | input | 5 | Rotate count, or bit index (low 4 bits) |
| cf_in | input | 1 | Incoming carry flag |
| zf_in | input | 1 | Incoming zero flag |
| result | output | 16 | Registered result value |
| cf_out | output | 1 | Registered carry flag |
| zf_out | output | 1 | Registered zero flag |
| done | output | 1 | One-cycle strobe, result valid |

## Verification
Presenting one request's outputs and capturing the next request can fall in the same cycle. The unit must raise `done` for request N while it latches request N+1. The bench provokes this with long runs of back-to-back starts of random operations, counts and flags, broken by random idle gaps. Each expected item is stamped with the cycle in which its strobe is due, so a lost, doubled or late strobe shows up as a cycle mismatch. The idle gaps check that the outputs hold.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [3:0] {
    OP_ROL = 4'd0,
    OP_ROR = 4'd1,
    OP_RCL = 4'd2,
    OP_RCR = 4'd3,
    OP_BT  = 4'd4,
    OP_BTS = 4'd5,
    OP_BTR = 4'd6,
    OP_BTC = 4'd7,
    OP_BSF = 4'd8,
    OP_BSR = 4'd9
  } bru_op_e;

  function automatic logic is_rotate(input bru_op_e o);
    return (o == OP_ROL) || (o == OP_ROR) || (o == OP_RCL) || (o == OP_RCR);
  endfunction

  function automatic logic is_bittest(input bru_op_e o);
    return (o == OP_BT) || (o == OP_BTS) || (o == OP_BTR) || (o == OP_BTC);
  endfunction

  function automatic logic is_scan(input bru_op_e o);
    return (o == OP_BSF) || (o == OP_BSR);
  endfunction

endpackage

// File: rtl/bru_rot_core.sv
module bru_rot_core
  import bru_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 5
) (
  input  bru_op_e          op,
  input  logic [W-1:0]     src,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cf_in,
  output logic [W-1:0]     res,
  output logic             cf_out
);
  localparam int XW = W + 1;

  logic [CNT_W-1:0] n_plain;
  logic [CNT_W-1:0] n_thru;
  logic [W-1:0]     rl, rr;
  logic [XW-1:0]    ext, xl, xr;

  assign n_plain = CNT_W'(cnt % CNT_W'(W));
  assign n_thru  = CNT_W'(cnt % CNT_W'(XW));
  assign ext     = {cf_in, src};

  assign rl = (src << n_plain) | (src >> (W - n_plain));
  assign rr = (src >> n_plain) | (src << (W - n_plain));
  assign xl = (ext << n_thru) | (ext >> (XW - n_thru));
  assign xr = (ext >> n_thru) | (ext << (XW - n_thru));

  always_comb begin
    res    = src;
    cf_out = cf_in;
    if (cnt != '0) begin
      unique case (op)
        OP_ROL:  begin res = rl;         cf_out = rl[0];   end
        OP_ROR:  begin res = rr;         cf_out = rr[W-1]; end
        OP_RCL:  begin res = xl[W-1:0];  cf_out = xl[W];   end
        OP_RCR:  begin res = xr[W-1:0];  cf_out = xr[W];   end
        default: begin res = src;        cf_out = cf_in;   end
      endcase
    end
  end
endmodule

// File: rtl/bru_bit_core.sv
module bru_bit_core
  import bru_pkg::*;
#(
  parameter int W     = 16,
  parameter int IDX_W = 4
) (
  input  bru_op_e          op,
  input  logic [W-1:0]     src,
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     res,
  output logic             cf_out
);
  logic [W-1:0] sel;

  for (genvar g = 0; g < W; g++) begin : g_sel
    assign sel[g] = (idx == IDX_W'(g));
  end

  assign cf_out = |(src & sel);

  always_comb begin
    unique case (op)
      OP_BTS:  res = src | sel;
      OP_BTR:  res = src & ~sel;
      OP_BTC:  res = src ^ sel;
      default: res = src;
    endcase
  end
endmodule

// File: rtl/bru_scan_core.sv
module bru_scan_core #(
  parameter int W     = 16,
  parameter int IDX_W = 4
) (
  input  logic         rev,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dest,
  output logic [W-1:0] res,
  output logic         zf_out
);
  logic [IDX_W-1:0] fwd_idx, bwd_idx;

  always_comb begin
    fwd_idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (src[i]) fwd_idx = IDX_W'(i);
    end
  end

  always_comb begin
    bwd_idx = '0;
    for (int i = 0; i < W; i++) begin
      if (src[i]) bwd_idx = IDX_W'(i);
    end
  end

  assign zf_out = (src == '0);

  always_comb begin
    if (zf_out)  res = dest;
    else if (rev) res = {{(W-IDX_W){1'b0}}, bwd_idx};
    else          res = {{(W-IDX_W){1'b0}}, fwd_idx};
  end
endmodule

// File: rtl/bitrot_unit.sv
module bitrot_unit
  import bru_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       op,
  input  logic [W-1:0]     operand,
  input  logic [W-1:0]     dest_in,
  input  logic [CNT_W-1:0] count,
  input  logic             cf_in,
  input  logic             zf_in,
  output logic [W-1:0]     result,
  output logic             cf_out,
  output logic             zf_out,
  output logic             done
);
  localparam int IDX_W = $clog2(W);

  bru_op_e      op_e;
  logic [W-1:0] rot_res, bit_res, scan_res, nxt_res;
  logic         rot_cf, bit_cf, scan_zf, nxt_cf, nxt_zf;

  assign op_e = bru_op_e'(op);

  bru_rot_core #(.W(W), .CNT_W(CNT_W)) u_rot (
    .op(op_e), .src(operand), .cnt(count), .cf_in(cf_in),
    .res(rot_res), .cf_out(rot_cf)
  );

  bru_bit_core #(.W(W), .IDX_W(IDX_W)) u_bit (
    .op(op_e), .src(operand), .idx(count[IDX_W-1:0]),
    .res(bit_res), .cf_out(bit_cf)
  );

  bru_scan_core #(.W(W), .IDX_W(IDX_W)) u_scan (
    .rev(op_e == OP_BSR), .src(operand), .dest(dest_in),
    .res(scan_res), .zf_out(scan_zf)
  );

  always_comb begin
    nxt_res = operand;
    nxt_cf  = cf_in;
    nxt_zf  = zf_in;
    if (is_rotate(op_e)) begin
      nxt_res = rot_res;
      nxt_cf  = rot_cf;
    end else if (is_bittest(op_e)) begin
      nxt_res = bit_res;
      nxt_cf  = bit_cf;
    end else if (is_scan(op_e)) begin
      nxt_res = scan_res;
      nxt_zf  = scan_zf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      cf_out <= 1'b0;
      zf_out <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result <= nxt_res;
        cf_out <= nxt_cf;
        zf_out <= nxt_zf;
      end
    end
  end

  // R9
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R9
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(cf_out) && $stable(zf_out)));

  // R3
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op[3:2] == 2'b00 && count == '0) |=>
      (result == $past(operand) && cf_out == $past(cf_in) && zf_out == $past(zf_in)));

  // R4
  test_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 4'd4) |=> (result == $past(operand) && zf_out == $past(zf_in)));

  // R8
  scan_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op == 4'd8 || op == 4'd9) && operand == '0) |=>
      (zf_out && result == $past(dest_in) && cf_out == $past(cf_in)));
endmodule

// File: tb/bitrot_unit_test.sv
module bitrot_unit_test;
  localparam int W  = 16;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    op = '0;
  logic [W-1:0]  operand = '0, dest_in = '0;
  logic [CW-1:0] count = '0;
  logic          cf_in = 1'b0, zf_in = 1'b0;
  logic [W-1:0]  result;
  logic          cf_out, zf_out, done;

  bitrot_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
    .dest_in(dest_in), .count(count), .cf_in(cf_in), .zf_in(zf_in),
    .result(result), .cf_out(cf_out), .zf_out(zf_out), .done(done)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [W-1:0] r;
    logic         cf;
    logic         zf;
    int           cyc;
    string        tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] o, input logic [W-1:0] a, d,
                                input logic [CW-1:0] c, input logic ci, zi,
                                output logic [W-1:0] r, output logic cf, zf);
    logic t;
    r = a; cf = ci; zf = zi;
    case (o)
      4'd0: for (int i = 0; i < int'(c); i++) begin cf = r[W-1]; r = {r[W-2:0], r[W-1]}; end
      4'd1: for (int i = 0; i < int'(c); i++) begin cf = r[0]; r = {r[0], r[W-1:1]}; end
      4'd2: for (int i = 0; i < int'(c); i++) begin t = r[W-1]; r = {r[W-2:0], cf}; cf = t; end
      4'd3: for (int i = 0; i < int'(c); i++) begin t = r[0]; r = {cf, r[W-1:1]}; cf = t; end
      4'd4, 4'd5, 4'd6, 4'd7: begin
        cf = a[c[3:0]];
        if (o == 4'd5) r[c[3:0]] = 1'b1;
        if (o == 4'd6) r[c[3:0]] = 1'b0;
        if (o == 4'd7) r[c[3:0]] = ~a[c[3:0]];
      end
      4'd8, 4'd9: begin
        if (a == '0) begin zf = 1'b1; r = d; end
        else begin
          zf = 1'b0;
          if (o == 4'd8) begin
            for (int i = W - 1; i >= 0; i--) if (a[i]) r = W'(i);
          end else begin
            for (int i = 0; i < W; i++) if (a[i]) r = W'(i);
          end
        end
      end
      default: ;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic [W-1:0] a,
                                   input logic [CW-1:0] c);
    if (o < 4'd4) return (c == '0) ? "R3" : ((o < 4'd2) ? "R1" : "R2");
    if (o == 4'd4) return "R4";
    if (o < 4'd8) return "R5";
    if (o < 4'd10) return (a == '0) ? "R8" : ((o == 4'd8) ? "R6" : "R7");
    return "R11";
  endfunction

  // Driver: presents one request for one cycle and queues the expected item
  task automatic issue(input logic [3:0] o, input logic [W-1:0] a, d,
                       input logic [CW-1:0] c, input logic ci, zi);
    exp_t e;
    op = o; operand = a; dest_in = d; count = c; cf_in = ci; zf_in = zi;
    start = 1'b1;
    model(o, a, d, c, ci, zi, e.r, e.cf, e.zf);
    e.cyc = cyc + 1;
    e.tag = tag_of(o, a, c);
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares each strobed result; checks holding otherwise
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.cyc, "R9", "strobe cycle", cyc, e.cyc);
          check(result == e.r, e.tag, "result", result, e.r);
          check(cf_out == e.cf, e.tag, "cf", cf_out, e.cf);
          check(zf_out == e.zf, e.tag, "zf", zf_out, e.zf);
          last = e;
        end
      end else begin
        if (q.size() != 0 && q[0].cyc < cyc)
          check(1'b0, "R9", "missing done", cyc, q[0].cyc);
        check(result == last.r && cf_out == last.cf && zf_out == last.zf,
              "R10", "hold", {cf_out, zf_out, result}, {last.cf, last.zf, last.r});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    last.r = '0; last.cf = 1'b0; last.zf = 1'b0; last.cyc = 0; last.tag = "R10";
    repeat (3) @(negedge clk);
    check(result == '0 && cf_out == 1'b0 && zf_out == 1'b0 && done == 1'b0,
          "R10", "reset state", {done, cf_out, zf_out, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: carry example, rotates, zero and large counts (R1 R2 R3)
    issue(4'd2, 16'h4020, 16'h0, 5'd5,  1'b1, 1'b0);
    issue(4'd0, 16'h8001, 16'h0, 5'd1,  1'b0, 1'b1);
    issue(4'd1, 16'h8001, 16'h0, 5'd16, 1'b0, 1'b0);
    issue(4'd0, 16'h1234, 16'h0, 5'd0,  1'b1, 1'b1);
    issue(4'd3, 16'hABCD, 16'h0, 5'd0,  1'b1, 1'b0);
    issue(4'd2, 16'hABCD, 16'h0, 5'd17, 1'b1, 1'b0);
    issue(4'd3, 16'h0001, 16'h0, 5'd31, 1'b0, 1'b1);
    issue(4'd0, 16'hF00F, 16'h0, 5'd31, 1'b0, 1'b0);
    idle(2);
    // Bit tests with index beyond width (R4 R5)
    issue(4'd4, 16'h0010, 16'h0, 5'd20, 1'b0, 1'b1);
    issue(4'd5, 16'h0000, 16'h0, 5'd15, 1'b1, 1'b0);
    issue(4'd6, 16'hFFFF, 16'h0, 5'd31, 1'b0, 1'b0);
    issue(4'd7, 16'h00F0, 16'h0, 5'd4,  1'b0, 1'b0);
    // Scans, including zero source (R6 R7 R8)
    issue(4'd8, 16'h0100, 16'h0, 5'd0, 1'b1, 1'b1);
    issue(4'd9, 16'h0101, 16'h0, 5'd0, 1'b0, 1'b1);
    issue(4'd8, 16'h0000, 16'hBEEF, 5'd0, 1'b1, 1'b0);
    issue(4'd9, 16'h0000, 16'h1357, 5'd0, 1'b0, 1'b0);
    // Undefined codes (R11)
    issue(4'd12, 16'h5A5A, 16'h0, 5'd3, 1'b1, 1'b0);
    issue(4'd15, 16'hA5A5, 16'h0, 5'd9, 1'b0, 1'b1);
    idle(3);

    // Random back-to-back traffic with gaps
    for (int k = 0; k < 1500; k++) begin
      logic [3:0] o;
      logic [W-1:0] a;
      o = 4'($urandom_range(0, 11));
      if ($urandom_range(0, 15) == 0) o = 4'($urandom_range(12, 15));
      a = W'($urandom);
      if ($urandom_range(0, 9) == 0) a = '0;
      issue(o, a, W'($urandom), CW'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 5) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    check(q.size() == 0, "R9", "drained", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule